// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside a receive MAC and decides, from the first six octets of an incoming frame, whether the frame is addressed to this station. The octets arrive one per accepted strobe, with a start-of-frame marker on the first one. While they stream in, the block shifts them into an address register and runs the reflected Ethernet CRC-32 over them. After the sixth octet it issues a single-cycle decision strobe carrying accept or reject.

The configuration inputs are the station address, split unevenly across a 16-bit high word and a 32-bit low word, and a 64-bit group hash table held as two 32-bit words. Three mode bits are also inputs: promiscuous, broadcast rejection and hashed unicast matching. Frame reception, FCS checking and buffering belong to neighbouring blocks.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0, and the block waits for a start-of-frame octet.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth address octet. Idle cycles between octets are allowed. Octets after the sixth and before the next start marker are ignored.
- R3: An octet with `in_sof` high always begins a new address, even partway through one. Octets without `in_sof` while the block is idle are ignored.
- R4: Received octet k (k = 0 first) is address byte k. Byte 0 is compared with `cfg_station_hi[15:8]` and byte 1 with `cfg_station_hi[7:0]`. Bytes 2 to 5 are compared with `cfg_station_lo` from bits 31:24 down to bits 7:0. A unicast address equal to the station address is accepted.
- R5: With `cfg_ind_hash` low, a unicast address that differs from the station address in any bit is rejected.
- R6: With `cfg_ind_hash` high, a non-matching unicast address is accepted exactly when its hash bit is set.
- R7: An address is a group address when bit 0 of byte 0 is 1 and not all 48 bits are 1. A group address is accepted exactly when its hash bit is set. The hash index is bits 31:26 of the CRC register. Index bit 5 selects `cfg_hash_hi` (1) or `cfg_hash_lo` (0), and index bits 4:0 select the bit within that word.
- R8: With both hash words all ones, every group address is accepted.
- R9: An all-ones address is rejected when `cfg_bcast_reject` is 1 and accepted when it is 0, whatever the hash table holds.
- R10: With `cfg_promisc` high, every address is accepted.
- R11: The CRC register starts at 0xFFFFFFFF. Each octet is consumed LSB first, using the reflected polynomial 0xEDB88320, and no final inversion is applied before the index is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An address octet is present |
| in_sof | input | 1 | The present octet is the first of a frame |
| in_byte | input | 8 | Address octet |
| cfg_station_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| cfg_station_lo | input | 32 | Station address bytes 2 (31:24) to 5 (7:0) |
| cfg_hash_lo | input | 32 | Hash table bits for index 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table bits for index 32 to 63 |
| cfg_bcast_reject | input | 1 | Reject all-ones addresses |
| cfg_ind_hash | input | 1 | Allow hashed unicast acceptance |
| cfg_promisc | input | 1 | Accept every address |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Accept flag, qualified by `dec_valid` |

## Verification
The bench drives all 64 hash indices. For each one it finds an address that lands on that index and loads a one-hot table and then its complement. A mistake in CRC bit order, initial value, index slice or word selection therefore turns into a wrong accept. Each of the 48 station bits is mismatched in turn, so a swapped byte lane or word split produces a false accept. Broadcast is tested with both empty and full hash tables, so a design that sends broadcast through the hash path is caught. Restarted addresses, gaps between octets and trailing octets check that the strobe comes exactly once and on the right octets. A design that counts trailing octets would strobe twice.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int OCTET_W    = 8;
  localparam int ADDR_W     = ADDR_BYTES * OCTET_W;
  localparam int CRC_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_WORD_W = 32;

  // One octet through the reflected CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] crc_in,
                                                 input logic [OCTET_W-1:0] octet,
                                                 input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int b = 0; b < OCTET_W; b++) begin
      c = (c >> 1) ^ (poly & {CRC_W{c[0] ^ octet[b]}});
    end
    return c;
  endfunction

  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [CRC_W-1:0] crc);
    return crc[CRC_W-1 -: HASH_IDX_W];
  endfunction

  function automatic logic hash_lookup(input logic [HASH_IDX_W-1:0] idx,
                                       input logic [HASH_WORD_W-1:0] word0,
                                       input logic [HASH_WORD_W-1:0] word1);
    logic [HASH_WORD_W-1:0] w;
    w = idx[HASH_IDX_W-1] ? word1 : word0;
    return w[idx[HASH_IDX_W-2:0]];
  endfunction
endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
  import dafilt_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic [OCTET_W-1:0]        in_byte,
  output logic                      take,
  output logic                      last_byte,
  output logic [NBYTES*OCTET_W-1:0] addr_q,
  output logic                      done_q
);
  localparam int AW = NBYTES * OCTET_W;
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  assign take      = in_valid && (in_sof || (cnt_q < FULL));
  assign last_byte = take && (in_sof ? (NBYTES == 1) : (cnt_q == FULL - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= FULL;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_byte;
      if (take) begin
        cnt_q  <= in_sof ? ONE : cnt_q + ONE;
        addr_q <= {addr_q[AW-OCTET_W-1:0], in_byte};
      end
    end
  end
endmodule

// File: rtl/dafilt_crc.sv
module dafilt_crc
  import dafilt_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               in_sof,
  input  logic [OCTET_W-1:0] in_byte,
  output logic [CRC_W-1:0]   crc_q
);
  logic [CRC_W-1:0] seed;
  assign seed = in_sof ? {CRC_W{1'b1}} : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= {CRC_W{1'b1}};
    else if (take) crc_q <= crc_octet(seed, in_byte, POLY);
  end
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
(
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CRC_W-1:0]       crc,
  input  logic [15:0]            station_hi,
  input  logic [31:0]            station_lo,
  input  logic [HASH_WORD_W-1:0] hash_lo,
  input  logic [HASH_WORD_W-1:0] hash_hi,
  input  logic                   bcast_reject,
  input  logic                   ind_hash,
  input  logic                   promisc,
  output logic                   is_bcast,
  output logic                   is_mcast,
  output logic                   station_hit,
  output logic                   hash_bit,
  output logic                   accept
);
  assign is_bcast    = &addr;
  assign is_mcast    = addr[ADDR_W-OCTET_W] && !is_bcast;
  assign station_hit = (addr == {station_hi, station_lo});
  assign hash_bit    = hash_lookup(hash_index(crc), hash_lo, hash_hi);

  always_comb begin
    if (promisc)       accept = 1'b1;
    else if (is_bcast) accept = !bcast_reject;
    else if (is_mcast) accept = hash_bit;
    else               accept = station_hit || (ind_hash && hash_bit);
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import dafilt_pkg::*;
#(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_byte,
  input  logic [15:0] cfg_station_hi,
  input  logic [31:0] cfg_station_lo,
  input  logic [31:0] cfg_hash_lo,
  input  logic [31:0] cfg_hash_hi,
  input  logic        cfg_bcast_reject,
  input  logic        cfg_ind_hash,
  input  logic        cfg_promisc,
  output logic        dec_valid,
  output logic        dec_accept
);
  logic              take;
  logic              last_byte;
  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  crc_q;
  logic              is_bcast, is_mcast, station_hit, hash_bit, accept_raw;

  dafilt_capture #(.NBYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .take(take), .last_byte(last_byte),
    .addr_q(addr_q), .done_q(dec_valid)
  );

  dafilt_crc #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .in_sof(in_sof),
    .in_byte(in_byte), .crc_q(crc_q)
  );

  dafilt_decide u_dec (
    .addr(addr_q), .crc(crc_q), .station_hi(cfg_station_hi),
    .station_lo(cfg_station_lo), .hash_lo(cfg_hash_lo), .hash_hi(cfg_hash_hi),
    .bcast_reject(cfg_bcast_reject), .ind_hash(cfg_ind_hash),
    .promisc(cfg_promisc), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .station_hit(station_hit), .hash_bit(hash_bit), .accept(accept_raw)
  );

  assign dec_accept = dec_valid && accept_raw;
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic last_byte,
  input logic dec_valid,
  input logic dec_accept,
  input logic is_bcast,
  input logic is_mcast,
  input logic station_hit,
  input logic hash_bit,
  input logic cfg_bcast_reject,
  input logic cfg_ind_hash,
  input logic cfg_promisc
);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  // R2
  strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> dec_valid);
  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(last_byte));
  // R10
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_promisc) |-> dec_accept);
  // R9
  bcast_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && is_bcast) |-> (dec_accept == !cfg_bcast_reject));
  // R7
  group_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && is_mcast) |-> (dec_accept == hash_bit));
  // R4
  station_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && station_hit) |-> dec_accept);
  // R5
  unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && !is_bcast && !is_mcast && !station_hit && !cfg_ind_hash)
      |-> !dec_accept);
  // R6
  ind_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && !is_bcast && !is_mcast && !station_hit && cfg_ind_hash)
      |-> (dec_accept == hash_bit));
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .last_byte(last_byte), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .is_bcast(is_bcast), .is_mcast(is_mcast),
  .station_hit(station_hit), .hash_bit(hash_bit),
  .cfg_bcast_reject(cfg_bcast_reject), .cfg_ind_hash(cfg_ind_hash),
  .cfg_promisc(cfg_promisc)
);

// File: tb/dest_addr_filter_bench.sv
`timescale 1ns/1ps
module dest_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [15:0] st_hi = '0;
  logic [31:0] st_lo = '0, h_lo = '0, h_hi = '0;
  logic        brej = 1'b0, ihash = 1'b0, prom = 1'b0;
  logic        dec_valid, dec_accept;

  int vectors = 0;
  int misses  = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .cfg_station_hi(st_hi), .cfg_station_lo(st_lo),
    .cfg_hash_lo(h_lo), .cfg_hash_hi(h_hi), .cfg_bcast_reject(brej),
    .cfg_ind_hash(ihash), .cfg_promisc(prom), .dec_valid(dec_valid),
    .dec_accept(dec_accept)
  );

  function automatic logic [47:0] rnd48();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng[47:0];
  endfunction

  // R11: reference CRC, bit-serial LSB first, init all ones, no final inversion
  function automatic int idx_of(logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] o = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ o[j];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return int'(c >> 26);
  endfunction

  function automatic logic model(logic [47:0] a);
    logic [63:0] tbl = {h_hi, h_lo};
    logic hb = tbl[idx_of(a)];
    if (prom) return 1'b1;
    if (a == 48'hFFFFFFFFFFFF) return !brej;
    if (a[40]) return hb;
    if (a == {st_hi, st_lo}) return 1'b1;
    return ihash && hb;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic send_frame(logic [47:0] a, bit gap, logic exp, string tag);
    logic v1, acc, v2;
    for (int i = 0; i < 6; i++) begin
      if (gap && i == 3) begin
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_byte = a[47-8*i -: 8];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    v1 = dec_valid; acc = dec_accept;
    @(negedge clk);
    v2 = dec_valid;
    check("R2 strobe", v1, 1'b1);
    check("R2 single", v2, 1'b0);
    check(tag, acc, exp);
  endtask

  task automatic loose_bytes(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2/R3 ignored octet", dec_valid, 1'b0);
      in_valid = 1'b1; in_sof = 1'b0; in_byte = base + 8'(i);
    end
    @(negedge clk); in_valid = 1'b0;
    check("R2/R3 ignored octet", dec_valid, 1'b0);
    @(negedge clk);
    check("R2/R3 ignored octet", dec_valid, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [47:0] a, b;
    repeat (3) @(negedge clk);
    // R1
    check("R1 valid at reset", dec_valid, 1'b0);
    check("R1 accept at reset", dec_accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", dec_valid, 1'b0);
    // R3: octets without a start marker while idle are dropped
    loose_bytes(8, 8'h10);

    // R7 / R11: exhaustive over the 64 hash indices
    for (int idx = 0; idx < 64; idx++) begin
      int tries = 0;
      do begin
        a = rnd48(); a[40] = 1'b1; tries++;
      end while ((idx_of(a) != idx || a == 48'hFFFFFFFFFFFF) && tries < 20000);
      {h_hi, h_lo} = 64'd1 << idx;
      send_frame(a, idx[0], 1'b1, "R7 group hit");
      {h_hi, h_lo} = ~(64'd1 << idx);
      send_frame(a, 1'b0, 1'b0, "R7 group miss");
    end

    // R4 / R5: exact match, then every single-bit mismatch
    {h_hi, h_lo} = '0;
    a = rnd48(); a[40] = 1'b0;
    {st_hi, st_lo} = a;
    send_frame(a, 1'b0, 1'b1, "R4 station match");
    for (int k = 0; k < 48; k++) begin
      {st_hi, st_lo} = a ^ (48'd1 << k);
      send_frame(a, 1'b0, 1'b0, "R5 station mismatch");
    end

    // R6: hashed unicast
    {st_hi, st_lo} = ~a;
    {h_hi, h_lo} = 64'd1 << idx_of(a);
    ihash = 1'b1;
    send_frame(a, 1'b0, 1'b1, "R6 hashed unicast hit");
    {h_hi, h_lo} = ~(64'd1 << idx_of(a));
    send_frame(a, 1'b0, 1'b0, "R6 hashed unicast miss");
    ihash = 1'b0;
    {h_hi, h_lo} = 64'd1 << idx_of(a);
    send_frame(a, 1'b0, 1'b0, "R5 hash ignored without mode");

    // R9: broadcast is independent of the hash table
    for (int m = 0; m < 4; m++) begin
      brej = m[0];
      {h_hi, h_lo} = m[1] ? '1 : '0;
      send_frame(48'hFFFFFFFFFFFF, 1'b0, !brej, "R9 broadcast");
    end
    brej = 1'b0;

    // R8: full table accepts every group address
    {h_hi, h_lo} = '1;
    for (int n = 0; n < 32; n++) begin
      a = rnd48(); a[40] = 1'b1;
      if (a == 48'hFFFFFFFFFFFF) a[0] = 1'b0;
      send_frame(a, n[0], 1'b1, "R8 all-ones table");
    end

    // R10: promiscuous with empty table, broadcast rejected
    {h_hi, h_lo} = '0; prom = 1'b1; brej = 1'b1;
    for (int n = 0; n < 24; n++) begin
      a = (n == 0) ? 48'hFFFFFFFFFFFF : rnd48();
      send_frame(a, 1'b0, 1'b1, "R10 promiscuous");
    end
    prom = 1'b0; brej = 1'b0;

    // R2: trailing octets after a complete address give no second strobe
    b = rnd48(); b[40] = 1'b0;
    {st_hi, st_lo} = b;
    send_frame(b, 1'b0, 1'b1, "R4 station match");
    loose_bytes(5, 8'hA0);

    // R3: restart partway through an address
    a = rnd48();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_byte = a[47-8*i -: 8];
    end
    send_frame(b, 1'b0, 1'b1, "R3 restarted address");

    // Mixed random configurations against the reference model
    for (int n = 0; n < 300; n++) begin
      logic [47:0] r = rnd48();
      if (n % 5 == 0) r = {st_hi, st_lo};
      if (n % 11 == 0) r = 48'hFFFFFFFFFFFF;
      h_lo = rnd48()[31:0]; h_hi = rnd48()[31:0];
      brej = rnd48()[3]; ihash = rnd48()[5]; prom = (rnd48()[9:7] == 3'd0);
      send_frame(r, n[1], model(r), "R4-R10 mixed");
    end

    finish_run();
  end
endmodule